// File: doc/BRIEF.md
# Programmable Wake-Up Sleep Timer

This block decides when a chip leaves its low-power modes. A slow clock of the 32 kHz class drives a 31-bit up-counter. Software programs a 16-bit mantissa and a 2-bit resolution setting. The wake interval is the mantissa multiplied by 2^(5·resolution) slow-clock periods. Each time the counter reaches the programmed point, the block raises a one-cycle wake pulse in the fast clock domain, restarts the counter from zero, and so repeats the interval.

The timer logic runs in the fast domain. It is advanced by a tick that marks each rising edge of the slow clock, and that edge is brought across a two-flop synchronizer. This keeps register writes and the wake pulse in one clock domain.

The block also controls entry into the deepest timed sleep mode (mode 2). A request is granted only on a slow-clock edge, and only after enough edges have passed since the request was raised. At the moment of the grant, the block flags a sleep interval that would end too soon after entry.

Top module: `wake_timer`

## Requirements
- R1: After reset, `wake`, `sleep_grant` and `short_sleep` are low and the counter is zero.
- R2: Writes use `wr_sel` = 0 for mantissa bits 7:0, 1 for mantissa bits 15:8, and 2 for control. In the control byte, bit 0 enables the timer and bits 2:1 hold the resolution. While the timer runs, consecutive wake pulses are mantissa·2^(5·resolution) slow-clock rising edges apart.
- R3: A mantissa of zero makes the event fire on every slow-clock rising edge.
- R4: If the mantissa is written below the current scaled count, the event fires on the next slow-clock rising edge, without waiting for a counter wrap.
- R5: With the enable bit clear, or with `pmode` = 3, the timer is idle. No wake pulse is produced and the counter is held at zero, so after the timer is released the first event comes a full interval later.
- R6: Each event gives exactly one fast-clock-cycle `wake` pulse. The pulse starts a fixed latency after a slow-clock rising edge.
- R7: `sleep_grant` is a one-cycle pulse. It is given on the fourth slow-clock rising edge seen after `sleep_req` rises, so that at least two whole edges fall between request and entry. A held request is granted only once.
- R8: While `pmode` = 2, newly written mantissa and resolution values are held off. The interval in force at entry keeps running until `pmode` leaves 2, and the new values then apply.
- R9: On each grant, `short_sleep` is set if fewer than 384 slow-clock periods remain until the next event, and is cleared otherwise. It holds that value until the next grant.
- R10: `pmode` encodes modes 0, 1, 2 and 3 as values 0 to 3. The timer runs in modes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk | input | 1 | Slow timer clock, synchronized internally |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mantissa low, 1 mantissa high, 2 control |
| wr_data | input | 8 | Write data |
| pmode | input | 2 | Current power mode, 0 to 3 |
| sleep_req | input | 1 | Request to enter power mode 2, held until granted |
| sleep_grant | output | 1 | One-cycle grant for entry into power mode 2 |
| wake | output | 1 | One-cycle wake event pulse |
| short_sleep | output | 1 | Sleep interval at the last grant was under the minimum |

## Verification
The assertions assume that the slow clock period is at least several fast cycles, so that two ticks never fall on adjacent fast cycles. They also assume that the system drives `pmode` to 2 only after a grant. The bench produces the slow clock by dividing the fast clock by eight, with edges placed away from the fast sampling edge. It raises requests half a slow period away from any slow edge, and before each interval measurement it restarts the counter by clearing the enable bit.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CNT_W    = 31;
  localparam int MANT_W   = 16;
  localparam int RES_W    = 2;
  localparam int RES_STEP = 5;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [MANT_W-1:0] mant_t;
  typedef logic [RES_W-1:0]  res_t;

  typedef enum logic [1:0] {SEL_MLO = 2'd0, SEL_MHI = 2'd1, SEL_CTRL = 2'd2, SEL_NONE = 2'd3} sel_e;
  typedef enum logic [1:0] {PM0 = 2'd0, PM1 = 2'd1, PM2 = 2'd2, PM3 = 2'd3} pmode_e;

  // counter bits seen by the compare at a given resolution
  function automatic cnt_t scale_tap(cnt_t c, res_t r);
    return c >> (RES_STEP * int'(r));
  endfunction

  // full interval length in slow ticks
  function automatic cnt_t span(mant_t m, res_t r);
    cnt_t w;
    w = cnt_t'(m);
    return w << (RES_STEP * int'(r));
  endfunction

  // ticks left from a count to a target, floored at zero
  function automatic cnt_t left_to_go(cnt_t tgt, cnt_t now);
    return (tgt > now) ? (tgt - now) : '0;
  endfunction
endpackage

// File: rtl/wt_edge_sync.sv
module wt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign tick = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/wt_event_core.sv
module wt_event_core
  import wt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  running,
  input  mant_t mant,
  input  res_t  res,
  output cnt_t  cnt,
  output cnt_t  cnt_after,
  output logic  fire,
  output logic  wake
);
  cnt_t cnt_nx;
  logic hit;

  assign cnt_nx = cnt + cnt_t'(1);
  assign hit    = scale_tap(cnt_nx, res) >= cnt_t'(mant);
  assign fire   = tick & running & hit;

  always_comb begin
    if (!running)  cnt_after = '0;
    else if (tick) cnt_after = hit ? '0 : cnt_nx;
    else           cnt_after = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      wake <= 1'b0;
    end else begin
      cnt  <= cnt_after;
      wake <= fire;
    end
  end
endmodule

// File: rtl/wt_sleep_gate.sv
module wt_sleep_gate
  import wt_pkg::*;
#(
  parameter int LEAD_EDGES = 3,
  parameter int MIN_SLEEP  = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  input  cnt_t cnt_after,
  input  cnt_t tgt,
  output logic grant,
  output logic short_flag
);
  localparam int SW = $clog2(LEAD_EDGES + 1);

  logic [SW-1:0] seen;
  logic          done;
  logic          too_short;

  assign too_short = left_to_go(tgt, cnt_after) < cnt_t'(MIN_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen       <= '0;
      done       <= 1'b0;
      grant      <= 1'b0;
      short_flag <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (!req) begin
        seen <= '0;
        done <= 1'b0;
      end else if (tick && !done) begin
        if (seen == SW'(LEAD_EDGES)) begin
          grant      <= 1'b1;
          done       <= 1'b1;
          short_flag <= too_short;
        end else begin
          seen <= seen + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEAD_EDGES  = 3,
  parameter int MIN_SLEEP   = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic [1:0] pmode,
  input  logic       sleep_req,
  output logic       sleep_grant,
  output logic       wake,
  output logic       short_sleep
);
  mant_t prog_mant, act_mant, eff_mant;
  res_t  prog_res, act_res, eff_res;
  logic  prog_en;
  logic  in_pm2;
  logic  slow_tick;
  logic  run_ok;
  logic  evt_fire;
  cnt_t  cnt_q, cnt_upd, tgt;
  logic  unused_ctrl_hi;

  assign unused_ctrl_hi = ^wr_data[7:3];

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_mant <= '0;
      prog_res  <= '0;
      prog_en   <= 1'b0;
    end else if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_MLO:  prog_mant[7:0]  <= wr_data;
        SEL_MHI:  prog_mant[15:8] <= wr_data;
        SEL_CTRL: begin
          prog_en  <= wr_data[0];
          prog_res <= wr_data[2:1];
        end
        default: ;
      endcase
    end
  end

  // compare settings frozen while in mode 2
  assign in_pm2   = (pmode_e'(pmode) == PM2);
  assign eff_mant = in_pm2 ? act_mant : prog_mant;
  assign eff_res  = in_pm2 ? act_res  : prog_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mant <= '0;
      act_res  <= '0;
    end else if (!in_pm2) begin
      act_mant <= prog_mant;
      act_res  <= prog_res;
    end
  end

  assign run_ok = prog_en && (pmode_e'(pmode) != PM3);
  assign tgt    = span(eff_mant, eff_res);

  wt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (slow_clk),
    .tick (slow_tick)
  );

  wt_event_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slow_tick),
    .running  (run_ok),
    .mant     (eff_mant),
    .res      (eff_res),
    .cnt      (cnt_q),
    .cnt_after(cnt_upd),
    .fire     (evt_fire),
    .wake     (wake)
  );

  wt_sleep_gate #(.LEAD_EDGES(LEAD_EDGES), .MIN_SLEEP(MIN_SLEEP)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (slow_tick),
    .req       (sleep_req),
    .cnt_after (cnt_upd),
    .tgt       (tgt),
    .grant     (sleep_grant),
    .short_flag(short_sleep)
  );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk
  import wt_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic running,
  input logic fire,
  input logic wake,
  input logic grant,
  input logic sleep_req,
  input cnt_t cnt
);
  // R6: wake follows a slow edge and lasts one cycle
  a_r6_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(tick));
  a_r6_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  // R5: no wake without a running timer; idle counter sits at zero
  a_r5_wake_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(running));
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (cnt == '0));
  // R2: counter only steps by one or restarts
  a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick) |=> (cnt == $past(cnt) + cnt_t'(1) || cnt == '0));
  // R3: an event restarts the counter and produces a wake
  a_r3_fire_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wake && cnt == '0));
  // R7: grant is a single pulse on a slow edge while requested
  a_r7_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  a_r7_grant_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ($past(tick) && $past(sleep_req)));
endmodule

bind wake_timer wake_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (slow_tick),
  .running  (run_ok),
  .fire     (evt_fire),
  .wake     (wake),
  .grant    (sleep_grant),
  .sleep_req(sleep_req),
  .cnt      (cnt_q)
);

// File: tb/wake_timer_test.sv
module wake_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] pmode = 2'd0;
  logic       sleep_req = 1'b0;
  logic       sleep_grant, wake, short_sleep;

  localparam int SLOW_DIV = 8;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_cyc = 0, wcnt = 0, gcnt = 0, edges = 0;
  bit have_last = 0;
  int    exp_q[$];
  string tag_q[$];

  wake_timer uut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pmode(pmode), .sleep_req(sleep_req),
    .sleep_grant(sleep_grant), .wake(wake), .short_sleep(short_sleep)
  );

  always #10 clk = ~clk;

  // slow clock: fast clock divided by eight, edges on the fast falling edge
  always @(negedge clk) begin
    if (cyc % (SLOW_DIV / 2) == 0) slow_clk <= ~slow_clk;
  end

  always @(posedge clk) cyc++;
  always @(posedge slow_clk) edges++;

  task automatic check(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: pops expected wake intervals and compares
  always @(negedge clk) begin
    if (wake) begin
      wcnt++;
      if (have_last && exp_q.size() > 0) begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int m = (cyc - last_cyc) / SLOW_DIV;
        check(m == e, t, m, e);
      end
      last_cyc  = cyc;
      have_last = 1;
    end
    if (sleep_grant) gcnt++;
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int m, input int r, input bit en);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'(m));
    wr(2'd1, 8'(m >> 8));
    wr(2'd2, {5'd0, 2'(r), en});
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * SLOW_DIV) @(negedge clk);
  endtask

  // driver: queue n expected intervals, then wait for the monitor to drain them
  task automatic expect_period(input string tag, input int p, input int n);
    int guard;
    @(negedge clk); #1;
    have_last = 0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
    guard = 0;
    while (exp_q.size() > 0 && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q.size() > 0) begin
      check(0, {tag, " drain"}, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic grant_run(input string tag, input int m, input int r, input bit exp_short);
    int g0, guard;
    sleep_req = 1'b0;
    wait_ticks(2);
    cfg(m, r, 1'b1);
    @(negedge slow_clk); #1;
    edges = 0;
    g0 = gcnt;
    sleep_req = 1'b1;
    guard = 0;
    while (gcnt == g0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(edges == 4, "R7 grant edge count", edges, 4);
    check(short_sleep == exp_short, tag, short_sleep, exp_short);
    wait_ticks(6);
    check(gcnt == g0 + 1, "R7 single grant per request", gcnt - g0, 1);
    sleep_req = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int w0, c0, t;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(wake == 1'b0, "R1 wake at reset", wake, 0);
    check(sleep_grant == 1'b0, "R1 grant at reset", sleep_grant, 0);
    check(short_sleep == 1'b0, "R1 flag at reset", short_sleep, 0);
    rst_n = 1'b1;
    wait_ticks(3);
    check(wcnt == 0, "R1 no wake while disabled after reset", wcnt, 0);

    // R2 interval at several resolutions
    cfg(10, 0, 1'b1);
    expect_period("R2 res0 mant10", 10, 3);
    // R6 pulse width
    @(negedge clk);
    while (!wake) @(negedge clk);
    @(negedge clk);
    check(wake == 1'b0, "R6 wake one cycle", wake, 0);
    cfg(3, 1, 1'b1);
    expect_period("R2 res1 mant3", 96, 2);
    cfg(256, 0, 1'b1);
    expect_period("R2 high byte mant256", 256, 2);
    cfg(1, 2, 1'b1);
    expect_period("R2 res2 mant1", 1024, 2);

    // R3 zero mantissa
    cfg(0, 0, 1'b1);
    expect_period("R3 mant0 every edge", 1, 4);

    // R4 compare written below the count
    cfg(200, 0, 1'b1);
    wait_ticks(100);
    w0 = wcnt;
    wr(2'd0, 8'd50);
    wait_ticks(3);
    check(wcnt > w0, "R4 immediate event", wcnt - w0, 1);
    expect_period("R4 new interval", 50, 2);

    // R5 idle cases
    cfg(1, 0, 1'b0);
    w0 = wcnt;
    wait_ticks(30);
    check(wcnt == w0, "R5 disabled no wake", wcnt - w0, 0);
    cfg(40, 0, 1'b1);
    pmode = 2'd3;
    wait_ticks(2);
    w0 = wcnt;
    wait_ticks(80);
    check(wcnt == w0, "R5 mode3 no wake", wcnt - w0, 0);
    @(negedge clk); #1;
    c0 = cyc;
    pmode = 2'd1;
    while (wcnt == w0 && cyc - c0 < 1000) @(negedge clk);
    t = (last_cyc - c0) / SLOW_DIV;
    check(t >= 39 && t <= 41, "R5 R10 full interval after release", t, 40);

    // R8 updates held off in mode 2
    pmode = 2'd0;
    cfg(10, 0, 1'b1);
    pmode = 2'd2;
    expect_period("R8 mode2 interval", 10, 2);
    wr(2'd0, 8'd3);
    expect_period("R8 write held in mode2", 10, 2);
    pmode = 2'd0;
    expect_period("R8 write applied after mode2", 3, 2);

    // R7 and R9 sleep entry handshake and short-interval flag
    grant_run("R9 short flag mant10", 10, 0, 1'b1);
    grant_run("R9 long interval 640", 20, 1, 1'b0);
    grant_run("R9 short interval 352", 11, 1, 1'b1);

    summary();
    $finish;
  end
endmodule